// File: doc/BRIEF.md
# Shared Exclusive Reservation Monitor

This block tracks exclusive-access reservations for several processors that share one memory. Each processor owns one reservation slot. The slot holds a valid flag, the physical address and the access size of that processor's most recent exclusive load. The interconnect sends the block one command per cycle, together with the processor number, address and size. The block consults and updates its slots from that command. It is used only for memory regions that are shared: accesses to private regions never reach it.

There are four command kinds. A processor can set its reservation, or probe whether it still holds a reservation. The block can wipe every reservation that lands in the same 8-byte granule as an address. The last kind is a conditional probe-and-wipe, which models a successful exclusive doubleword store: the probe result is reported, and when the probe passes, all overlapping reservations of all processors are dropped.

The probe result appears one cycle after the command is accepted. A ready flag shows when commands are accepted.

Top module: `gx_resv_monitor`

## Requirements
- R1: While reset is asserted, `ready_o` and `probe_ok_o` are 0. Every slot resets to invalid, so a probe after reset returns 0. `ready_o` is 1 from the first clock edge after reset is released. Commands are accepted only when `cmd_valid_i` and `ready_o` are both 1.
- R2: `cmd_op_i` = 2'b00 (set) records address and size for processor `cmd_pid_i`. A later probe (`cmd_op_i` = 2'b01) by the same processor with the same address and size gives `probe_ok_o` = 1 in the cycle after the probe is accepted. `cmd_size_i` is log2 of the byte count, so 2'b11 means 8 bytes.
- R3: Reservations belong to a single processor. A probe by a processor other than the one that set the reservation returns 0.
- R4: A probe returns 0 when its address or its size differs from the stored reservation.
- R5: A new set command from a processor replaces that processor's earlier reservation.
- R6: A wipe command (`cmd_op_i` = 2'b10) invalidates the reservation of every processor whose stored address has the same bits above bit 2 as `cmd_addr_i`. This holds whatever the sizes and low address bits are. `probe_ok_o` is 0 after a wipe.
- R7: A wipe command leaves untouched any reservation held in a different 8-byte granule.
- R8: A probe-and-wipe (`cmd_op_i` = 2'b11) reports the probe result like R2. When the probe passes, it also wipes as in R6. When the probe fails, no slot changes.
- R9: A plain probe never changes any reservation.
- R10: `probe_ok_o` is 0 in any cycle that does not follow an accepted probe or probe-and-wipe.
- R11: A command presented with `cmd_valid_i` low has no effect.
- R12: A processor number of NPROC or above sets nothing, and its probes return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command kind: 00 set, 01 probe, 10 wipe, 11 probe-and-wipe |
| cmd_pid_i | input | PIDW | Requesting processor number |
| cmd_addr_i | input | AW | Physical address |
| cmd_size_i | input | 2 | log2 of access size in bytes |
| probe_ok_o | output | 1 | Probe passed (one cycle after the command) |
| ready_o | output | 1 | Block accepts commands |

## Verification
The bench sends a wipe from a third processor to an address with nonzero low bits inside a reserved granule. A design that compared full addresses when wiping would leave the stale reservation alive. A failed probe-and-wipe followed by a probe from the owner catches a design that wipes unconditionally. A probe from a second processor after a successful probe-and-wipe catches one that clears only the requester's slot. Further cases are aimed at other mistakes:
- A replaced reservation probed at its old address exposes a design that keeps several reservations per processor.
- A processor number beyond NPROC exposes index aliasing onto a real slot.
- A set with the strobe low exposes a decoder that ignores `cmd_valid_i`.

// File: rtl/gx_pkg.sv
package gx_pkg;

    typedef enum logic [1:0] {
        OP_SET        = 2'b00,
        OP_PROBE      = 2'b01,
        OP_WIPE       = 2'b10,
        OP_PROBE_WIPE = 2'b11
    } gx_op_e;

    localparam int SIZE_W = 2;

    typedef logic [SIZE_W-1:0] gx_size_t;

endpackage

// File: rtl/gx_decode.sv
module gx_decode
    import gx_pkg::*;
(
    input  logic   valid_i,
    input  logic   ready_i,
    input  gx_op_e op_i,
    output logic   set_o,
    output logic   probe_o,
    output logic   wipe_o,
    output logic   cwipe_o
);
    logic acc;

    always_comb begin
        acc     = valid_i && ready_i;
        set_o   = acc && (op_i == OP_SET);
        probe_o = acc && (op_i == OP_PROBE || op_i == OP_PROBE_WIPE);
        wipe_o  = acc && (op_i == OP_WIPE);
        cwipe_o = acc && (op_i == OP_PROBE_WIPE);
    end

endmodule

// File: rtl/gx_slot.sv
module gx_slot
    import gx_pkg::*;
#(
    parameter int AW         = 32,
    parameter int GRAN_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_i,
    input  logic          drop_i,
    input  logic [AW-1:0] addr_i,
    input  gx_size_t      size_i,
    output logic          hit_o
);
    localparam int GSH = $clog2(GRAN_BYTES);

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        gx_size_t      size;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        // the wipe is applied first, then a set overrides it
        if (drop_i && (slot_q.addr[AW-1:GSH] == addr_i[AW-1:GSH])) begin
            slot_d.vld = 1'b0;
        end
        if (set_i) begin
            slot_d.vld  = 1'b1;
            slot_d.addr = addr_i;
            slot_d.size = size_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign hit_o = slot_q.vld && (slot_q.addr == addr_i) && (slot_q.size == size_i);

endmodule

// File: rtl/gx_resv_monitor.sv
module gx_resv_monitor
    import gx_pkg::*;
#(
    parameter int NPROC      = 3,
    parameter int AW         = 32,
    parameter int GRAN_BYTES = 8,
    localparam int PIDW      = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid_i,
    input  logic [1:0]      cmd_op_i,
    input  logic [PIDW-1:0] cmd_pid_i,
    input  logic [AW-1:0]   cmd_addr_i,
    input  logic [1:0]      cmd_size_i,
    output logic            probe_ok_o,
    output logic            ready_o
);
    typedef struct packed {
        logic res;
        logic rdy;
    } top_t;

    top_t st_d, st_q;

    logic             dec_set, dec_probe, dec_wipe, dec_cwipe;
    logic [NPROC-1:0] sel;
    logic [NPROC-1:0] hit;
    logic             sel_hit;
    logic             drop_all;

    gx_decode u_dec (
        .valid_i (cmd_valid_i),
        .ready_i (st_q.rdy),
        .op_i    (gx_op_e'(cmd_op_i)),
        .set_o   (dec_set),
        .probe_o (dec_probe),
        .wipe_o  (dec_wipe),
        .cwipe_o (dec_cwipe)
    );

    for (genvar i = 0; i < NPROC; i++) begin : g_slot
        assign sel[i] = ({1'b0, cmd_pid_i} == (PIDW+1)'(i));

        gx_slot #(
            .AW         (AW),
            .GRAN_BYTES (GRAN_BYTES)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (dec_set && sel[i]),
            .drop_i (drop_all),
            .addr_i (cmd_addr_i),
            .size_i (cmd_size_i),
            .hit_o  (hit[i])
        );
    end

    always_comb begin
        sel_hit  = |(hit & sel);
        drop_all = dec_wipe || (dec_cwipe && sel_hit);
        st_d     = st_q;
        st_d.rdy = 1'b1;
        st_d.res = dec_probe && sel_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign probe_ok_o = st_q.res;
    assign ready_o    = st_q.rdy;

endmodule

// File: rtl/gx_resv_monitor_chk.sv
module gx_resv_monitor_chk #(
    parameter int NPROC      = 3,
    parameter int AW         = 32,
    localparam int PIDW      = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid_i,
    input logic [1:0]      cmd_op_i,
    input logic [PIDW-1:0] cmd_pid_i,
    input logic [AW-1:0]   cmd_addr_i,
    input logic [1:0]      cmd_size_i,
    input logic            probe_ok_o,
    input logic            ready_o
);
    logic acc;
    assign acc = cmd_valid_i && ready_o;

    // R1
    ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ready_o);

    // R10
    ok_needs_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probe_ok_o |-> $past(acc && cmd_op_i[0]));

    // R6
    wipe_gives_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc && cmd_op_i == 2'b10) |-> !probe_ok_o);

    // R12
    bad_pid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc && ({1'b0, cmd_pid_i} >= (PIDW+1)'(NPROC))) |-> !probe_ok_o);

    // R8
    consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc && cmd_op_i == 2'b11, 2) && $past(probe_ok_o, 1)
         && $past(acc && cmd_op_i == 2'b01, 1)
         && $past(cmd_pid_i, 1) == $past(cmd_pid_i, 2)
         && $past(cmd_addr_i, 1) == $past(cmd_addr_i, 2)
         && $past(cmd_size_i, 1) == $past(cmd_size_i, 2)) |-> !probe_ok_o);

endmodule

bind gx_resv_monitor gx_resv_monitor_chk #(.NPROC(NPROC), .AW(AW)) u_chk (.*);

// File: tb/gx_resv_monitor_test.sv
module gx_resv_monitor_test;
    localparam int PERIOD = 10;
    localparam int NPROC  = 3;
    localparam int AW     = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid_i = 1'b0;
    logic [1:0]  cmd_op_i = 2'b00;
    logic [1:0]  cmd_pid_i = 2'b00;
    logic [31:0] cmd_addr_i = '0;
    logic [1:0]  cmd_size_i = 2'b00;
    logic        probe_ok_o, ready_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    gx_resv_monitor #(.NPROC(NPROC), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
        .cmd_pid_i(cmd_pid_i), .cmd_addr_i(cmd_addr_i), .cmd_size_i(cmd_size_i),
        .probe_ok_o(probe_ok_o), .ready_o(ready_o)
    );

    typedef struct packed {
        logic        vld;
        logic [1:0]  op;
        logic [1:0]  pid;
        logic [31:0] addr;
        logic [1:0]  size;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'b01, 2'd0, 32'h100, 2'd3, 1'b0, 4'd1},  // R1 nothing reserved
        '{1'b1, 2'b00, 2'd0, 32'h100, 2'd3, 1'b0, 4'd10}, // R10 set gives 0
        '{1'b1, 2'b01, 2'd0, 32'h100, 2'd3, 1'b1, 4'd2},  // R2
        '{1'b1, 2'b01, 2'd0, 32'h100, 2'd3, 1'b1, 4'd9},  // R9 probe again
        '{1'b1, 2'b01, 2'd1, 32'h100, 2'd3, 1'b0, 4'd3},  // R3
        '{1'b1, 2'b01, 2'd0, 32'h108, 2'd3, 1'b0, 4'd4},  // R4 address
        '{1'b1, 2'b01, 2'd0, 32'h100, 2'd2, 1'b0, 4'd4},  // R4 size
        '{1'b1, 2'b00, 2'd1, 32'h100, 2'd3, 1'b0, 4'd10},
        '{1'b1, 2'b00, 2'd2, 32'h200, 2'd3, 1'b0, 4'd10},
        '{1'b1, 2'b10, 2'd2, 32'h304, 2'd2, 1'b0, 4'd7},  // R7 other granule
        '{1'b1, 2'b01, 2'd1, 32'h100, 2'd3, 1'b1, 4'd7},
        '{1'b1, 2'b01, 2'd2, 32'h200, 2'd3, 1'b1, 4'd7},
        '{1'b1, 2'b10, 2'd2, 32'h104, 2'd2, 1'b0, 4'd6},  // R6 same granule
        '{1'b1, 2'b01, 2'd0, 32'h100, 2'd3, 1'b0, 4'd6},
        '{1'b1, 2'b01, 2'd1, 32'h100, 2'd3, 1'b0, 4'd6},
        '{1'b1, 2'b01, 2'd2, 32'h200, 2'd3, 1'b1, 4'd7},
        '{1'b1, 2'b00, 2'd0, 32'h400, 2'd3, 1'b0, 4'd5},  // R5
        '{1'b1, 2'b00, 2'd0, 32'h500, 2'd3, 1'b0, 4'd5},
        '{1'b1, 2'b01, 2'd0, 32'h400, 2'd3, 1'b0, 4'd5},
        '{1'b1, 2'b01, 2'd0, 32'h500, 2'd3, 1'b1, 4'd5},
        '{1'b1, 2'b00, 2'd1, 32'h500, 2'd3, 1'b0, 4'd10},
        '{1'b1, 2'b11, 2'd2, 32'h500, 2'd3, 1'b0, 4'd8},  // R8 failing
        '{1'b1, 2'b01, 2'd0, 32'h500, 2'd3, 1'b1, 4'd8},
        '{1'b1, 2'b11, 2'd0, 32'h500, 2'd3, 1'b1, 4'd8},  // R8 passing
        '{1'b1, 2'b01, 2'd1, 32'h500, 2'd3, 1'b0, 4'd8},
        '{1'b1, 2'b01, 2'd0, 32'h500, 2'd3, 1'b0, 4'd8},
        '{1'b0, 2'b00, 2'd1, 32'h600, 2'd3, 1'b0, 4'd11}, // R11
        '{1'b1, 2'b01, 2'd1, 32'h600, 2'd3, 1'b0, 4'd11},
        '{1'b1, 2'b00, 2'd3, 32'h700, 2'd3, 1'b0, 4'd12}, // R12
        '{1'b1, 2'b01, 2'd3, 32'h700, 2'd3, 1'b0, 4'd12},
        '{1'b1, 2'b01, 2'd2, 32'h200, 2'd3, 1'b1, 4'd8},
        '{1'b1, 2'b11, 2'd2, 32'h200, 2'd3, 1'b1, 4'd8},
        '{1'b0, 2'b01, 2'd2, 32'h200, 2'd3, 1'b0, 4'd10}  // R10 idle
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] op, input logic [1:0] pid,
                         input logic [31:0] a, input logic [1:0] sz);
        cmd_valid_i = v;
        cmd_op_i    = op;
        cmd_pid_i   = pid;
        cmd_addr_i  = a;
        cmd_size_i  = sz;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ready in reset", ready_o, 1'b0);
        check("R1 result in reset", probe_ok_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", ready_o, 1'b1);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].vld, TBL[i].op, TBL[i].pid, TBL[i].addr, TBL[i].size);
            @(negedge clk);
            checks++;
            if (probe_ok_o !== TBL[i].exp) begin
                errors++;
                $display("FAIL R%0d (row %0d): got %b expected %b",
                         TBL[i].req, i, probe_ok_o, TBL[i].exp);
            end
        end

        // R1: reset in mid-run drops a live reservation
        drive(1'b1, 2'b00, 2'd0, 32'h800, 2'd3);
        @(negedge clk);
        drive(1'b1, 2'b01, 2'd0, 32'h800, 2'd3);
        @(negedge clk);
        check("R2 before reset", probe_ok_o, 1'b1);
        drive(1'b0, 2'b00, 2'd0, 32'h0, 2'd0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 ready low in reset", ready_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready back", ready_o, 1'b1);
        drive(1'b1, 2'b01, 2'd0, 32'h800, 2'd3);
        @(negedge clk);
        check("R1 slots cleared by reset", probe_ok_o, 1'b0);

        // R6: wipe with size 1 byte at the top of a granule
        drive(1'b1, 2'b00, 2'd1, 32'h900, 2'd3);
        @(negedge clk);
        drive(1'b1, 2'b10, 2'd0, 32'h907, 2'd0);
        @(negedge clk);
        drive(1'b1, 2'b01, 2'd1, 32'h900, 2'd3);
        @(negedge clk);
        check("R6 byte wipe", probe_ok_o, 1'b0);

        drive(1'b0, 2'b00, 2'd0, 32'h0, 2'd0);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule